// File: doc/BRIEF.md
# Pipeline Hazard Detection Unit

This is a purely combinational controller for a five-stage in-order pipeline: Fetch, Decode, Execute, Memory and Writeback. It looks at the source registers of the instructions in Decode and Execute, and at the destination registers and flags of the instructions further down the pipe. From these it steers the operand bypass multiplexers in front of the ALU. It also steers the bypass in front of the equality comparator that resolves branches early in Decode.

When a value cannot be bypassed in time, the unit holds the Fetch and Decode pipeline registers and clears the Execute pipeline register, which inserts a bubble. This happens when a load feeds the next instruction, or when a Decode branch depends on a result that is still being computed.

Register 0 is hard-wired to zero. It never creates a dependence.

Top module: `hzd_unit`

## Requirements
- R1: ALU operand select `fwdAE`/`fwdBE` uses these encodings: 2'b00 for the register file, 2'b01 for the Writeback result and 2'b10 for the Memory result. 2'b11 never appears. The select is 2'b10 when `regWrM` is 1 and `dstM` equals the operand's Execute source (`rsE` or `rtE`).
- R2: When the Memory stage does not match the operand, the select is 2'b01 if `regWrW` is 1 and `dstW` equals the operand's source. When both stages match, Memory wins.
- R3: Register 0 is never forwarded. A source of 0 gives select 2'b00 and comparator select 0. A destination of 0 never causes a stall.
- R4: Comparator select `fwdAD` is 1 when `regWrM` is 1 and `dstM` equals `rsD`, and 0 otherwise. `fwdBD` follows the same rule with `rtD`. This does not depend on `branchD`.
- R5: Load-use stall: all of `stallF`, `stallD` and `flushE` are 1 when `memToRegE` and `regWrE` are both 1 and `dstE` equals `rsD` or `rtD`.
- R6: Branch stall from Execute: the stall outputs are 1 when `branchD` and `regWrE` are both 1 and `dstE` equals `rsD` or `rtD`.
- R7: Branch stall from Memory: the stall outputs are 1 when `branchD`, `memToRegM` and `regWrM` are all 1 and `dstM` equals `rsD` or `rtD`.
- R8: `stallF`, `stallD` and `flushE` always carry the same value.
- R9: When none of the conditions in R5 to R7 holds, the stall outputs are 0. In particular, with `branchD` at 0, a non-load writer in Execute or a load in Memory causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rsD | input | REG_W | First source register of the Decode instruction |
| rtD | input | REG_W | Second source register of the Decode instruction |
| branchD | input | 1 | Decode instruction is a branch compared in Decode |
| rsE | input | REG_W | First source register of the Execute instruction |
| rtE | input | REG_W | Second source register of the Execute instruction |
| dstE | input | REG_W | Destination register of the Execute instruction |
| regWrE | input | 1 | Execute instruction writes a register |
| memToRegE | input | 1 | Execute instruction is a load |
| dstM | input | REG_W | Destination register of the Memory instruction |
| regWrM | input | 1 | Memory instruction writes a register |
| memToRegM | input | 1 | Memory instruction is a load |
| dstW | input | REG_W | Destination register of the Writeback instruction |
| regWrW | input | 1 | Writeback instruction writes a register |
| fwdAE | output | 2 | Bypass select for ALU operand A |
| fwdBE | output | 2 | Bypass select for ALU operand B |
| fwdAD | output | 1 | Bypass select for comparator operand A |
| fwdBD | output | 1 | Bypass select for comparator operand B |
| stallF | output | 1 | Hold the Fetch pipeline register |
| stallD | output | 1 | Hold the Decode pipeline register |
| flushE | output | 1 | Clear the Execute pipeline register |

## Verification
Every output is a combinational function of the current inputs, so each result is due in the same cycle as the stimulus that causes it, with no register in between. The bench changes the inputs just after a rising clock edge and compares every output against its reference model at the following falling edge. By then the inputs have been stable for half a period, and no sample lands on an edge at which the inputs move. The register numbers are drawn from a small range so that matches, double matches and register-0 cases occur often.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  // Bypass selection for an ALU operand
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwdSel_e;

  // Strobes raised by the compare path for the control path
  typedef struct packed {
    logic loadUseHit;
    logic brExecHit;
    logic brMemLoadHit;
  } hzdStrobe_t;

  // Pipeline-register controls
  typedef struct packed {
    logic stallFetch;
    logic stallDecode;
    logic flushExec;
  } stallCtl_t;

endpackage

// File: rtl/hzd_fwd_path.sv
module hzd_fwd_path
  import hzd_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int N_SRC = 2
) (
  input  logic [N_SRC-1:0][REG_W-1:0] srcD,
  input  logic [N_SRC-1:0][REG_W-1:0] srcE,
  input  logic [REG_W-1:0]            dstE,
  input  logic                        regWrE,
  input  logic                        memToRegE,
  input  logic [REG_W-1:0]            dstM,
  input  logic                        regWrM,
  input  logic                        memToRegM,
  input  logic [REG_W-1:0]            dstW,
  input  logic                        regWrW,
  output fwdSel_e [N_SRC-1:0]         fwdSelE,
  output logic [N_SRC-1:0]            fwdCmpD,
  output hzdStrobe_t                  strobe
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  // A stage can supply a value only if it writes a real register
  logic liveE, liveM, liveW, loadE, loadM;
  assign liveE = regWrE && (dstE != ZERO_REG);
  assign liveM = regWrM && (dstM != ZERO_REG);
  assign liveW = regWrW && (dstW != ZERO_REG);
  assign loadE = liveE && memToRegE;
  assign loadM = liveM && memToRegM;

  logic [N_SRC-1:0] hitLoadE, hitWrE, hitLoadM;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic matchMemE, matchWbE;
    assign matchMemE = liveM && (dstM == srcE[g]);
    assign matchWbE  = liveW && (dstW == srcE[g]);

    // Memory holds the younger result, so it takes priority
    always_comb begin
      if (matchMemE)     fwdSelE[g] = FWD_MEM;
      else if (matchWbE) fwdSelE[g] = FWD_WB;
      else               fwdSelE[g] = FWD_RF;
    end

    assign fwdCmpD[g]  = liveM && (dstM == srcD[g]);
    assign hitLoadE[g] = loadE && (dstE == srcD[g]);
    assign hitWrE[g]   = liveE && (dstE == srcD[g]);
    assign hitLoadM[g] = loadM && (dstM == srcD[g]);
  end

  assign strobe.loadUseHit   = |hitLoadE;
  assign strobe.brExecHit    = |hitWrE;
  assign strobe.brMemLoadHit = |hitLoadM;

endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
  import hzd_pkg::*;
(
  input  hzdStrobe_t strobe,
  input  logic       branchD,
  output stallCtl_t  ctl
);

  logic brStall, anyStall;

  // The early comparator needs a value that no bypass can deliver in time
  assign brStall  = branchD && (strobe.brExecHit || strobe.brMemLoadHit);
  assign anyStall = strobe.loadUseHit || brStall;

  // Hold every earlier stage and drop a bubble into Execute
  always_comb begin
    ctl.stallFetch  = anyStall;
    ctl.stallDecode = anyStall;
    ctl.flushExec   = anyStall;
  end

endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] rsD,
  input  logic [REG_W-1:0] rtD,
  input  logic             branchD,
  input  logic [REG_W-1:0] rsE,
  input  logic [REG_W-1:0] rtE,
  input  logic [REG_W-1:0] dstE,
  input  logic             regWrE,
  input  logic             memToRegE,
  input  logic [REG_W-1:0] dstM,
  input  logic             regWrM,
  input  logic             memToRegM,
  input  logic [REG_W-1:0] dstW,
  input  logic             regWrW,
  output logic [1:0]       fwdAE,
  output logic [1:0]       fwdBE,
  output logic             fwdAD,
  output logic             fwdBD,
  output logic             stallF,
  output logic             stallD,
  output logic             flushE
);

  localparam int N_SRC = 2;

  fwdSel_e [N_SRC-1:0] fwdSelE;
  logic [N_SRC-1:0]    fwdCmpD;
  hzdStrobe_t          strobe;
  stallCtl_t           ctl;

  hzd_fwd_path #(.REG_W(REG_W), .N_SRC(N_SRC)) fwd_i (
    .srcD      ({rtD, rsD}),
    .srcE      ({rtE, rsE}),
    .dstE      (dstE),
    .regWrE    (regWrE),
    .memToRegE (memToRegE),
    .dstM      (dstM),
    .regWrM    (regWrM),
    .memToRegM (memToRegM),
    .dstW      (dstW),
    .regWrW    (regWrW),
    .fwdSelE   (fwdSelE),
    .fwdCmpD   (fwdCmpD),
    .strobe    (strobe)
  );

  hzd_ctrl ctrl_i (
    .strobe  (strobe),
    .branchD (branchD),
    .ctl     (ctl)
  );

  assign fwdAE  = fwdSelE[0];
  assign fwdBE  = fwdSelE[1];
  assign fwdAD  = fwdCmpD[0];
  assign fwdBD  = fwdCmpD[1];
  assign stallF = ctl.stallFetch;
  assign stallD = ctl.stallDecode;
  assign flushE = ctl.flushExec;

endmodule

// File: rtl/hzd_unit_chk.sv
module hzd_unit_chk #(
  parameter int REG_W = 5
) (
  input logic [REG_W-1:0] rsD,
  input logic [REG_W-1:0] rtD,
  input logic             branchD,
  input logic [REG_W-1:0] rsE,
  input logic [REG_W-1:0] dstE,
  input logic             regWrE,
  input logic             memToRegE,
  input logic [REG_W-1:0] dstM,
  input logic             regWrM,
  input logic [1:0]       fwdAE,
  input logic [1:0]       fwdBE,
  input logic             fwdAD,
  input logic             stallF,
  input logic             stallD,
  input logic             flushE
);

  always_comb begin
    // R8
    stall_lockstep_chk: assert (stallF == stallD && stallD == flushE);
    // R1
    sel_code_chk: assert (fwdAE != 2'b11 && fwdBE != 2'b11);
    // R1
    mem_sel_src_chk: assert (fwdAE != 2'b10 || (regWrM && dstM == rsE));
    // R3
    zero_src_chk: assert (rsE != '0 || fwdAE == 2'b00);
    // R4
    cmp_fwd_chk: assert (!fwdAD || (regWrM && dstM == rsD && rsD != '0));
    // R5
    load_use_chk: assert (!(memToRegE && regWrE && dstE != '0 &&
                            (dstE == rsD || dstE == rtD)) || stallD);
    // R9
    quiet_chk: assert (branchD || (memToRegE && regWrE) || !stallD);
  end

endmodule

bind hzd_unit hzd_unit_chk #(.REG_W(REG_W)) chk_i (
  .rsD(rsD), .rtD(rtD), .branchD(branchD), .rsE(rsE), .dstE(dstE),
  .regWrE(regWrE), .memToRegE(memToRegE), .dstM(dstM), .regWrM(regWrM),
  .fwdAE(fwdAE), .fwdBE(fwdBE), .fwdAD(fwdAD), .stallF(stallF),
  .stallD(stallD), .flushE(flushE)
);

// File: tb/hzd_unit_tb_top.sv
module hzd_unit_tb_top;

  localparam int REG_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk; // 50 MHz

  logic [REG_W-1:0] rsD, rtD, rsE, rtE, dstE, dstM, dstW;
  logic branchD, regWrE, memToRegE, regWrM, memToRegM, regWrW;
  logic [1:0] fwdAE, fwdBE;
  logic fwdAD, fwdBD, stallF, stallD, flushE;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  hzd_unit #(.REG_W(REG_W)) dut_i (.*);

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  // Reference: ALU bypass choice for one source register
  function automatic int refSel(int src);
    if (src == 0) return 0;
    if (regWrM && int'(dstM) == src) return 2;
    if (regWrW && int'(dstW) == src) return 1;
    return 0;
  endfunction

  function automatic int refStall();
    int srcs[2];
    bit st = 0;
    srcs[0] = int'(rsD);
    srcs[1] = int'(rtD);
    foreach (srcs[i]) begin
      if (srcs[i] == 0) continue;
      if (regWrE && memToRegE && int'(dstE) == srcs[i]) st = 1;
      if (branchD && regWrE && int'(dstE) == srcs[i]) st = 1;
      if (branchD && regWrM && memToRegM && int'(dstM) == srcs[i]) st = 1;
    end
    return int'(st);
  endfunction

  task automatic compareAll(string tag);
    int s;
    s = refStall();
    check({tag, " R1 R2 R3 fwdAE"}, int'(fwdAE), refSel(int'(rsE)));
    check({tag, " R1 R2 R3 fwdBE"}, int'(fwdBE), refSel(int'(rtE)));
    check({tag, " R4 fwdAD"}, int'(fwdAD),
          (rsD != 0 && regWrM && dstM == rsD) ? 1 : 0);
    check({tag, " R4 fwdBD"}, int'(fwdBD),
          (rtD != 0 && regWrM && dstM == rtD) ? 1 : 0);
    check({tag, " R5 R6 R7 R9 stallF"}, int'(stallF), s);
    check({tag, " R8 stallD"}, int'(stallD), s);
    check({tag, " R8 flushE"}, int'(flushE), s);
  endtask

  task automatic clearIn();
    {rsD, rtD, rsE, rtE, dstE, dstM, dstW} = '0;
    {branchD, regWrE, memToRegE, regWrM, memToRegM, regWrW} = '0;
  endtask

  // Apply after a rising edge, sample at the falling edge
  task automatic step(string tag);
    @(negedge clk);
    compareAll(tag);
    @(posedge clk);
  endtask

  initial begin
    clearIn();
    repeat (3) @(posedge clk);
    rst = 1'b0;
    step("reset");
    // R1 and R2: both stages match, Memory wins
    rsE = 3; rtE = 4; dstM = 3; regWrM = 1; dstW = 3; regWrW = 1; step("R1 prio");
    dstM = 7; dstW = 4; step("R2 wb");
    // R3: register 0
    rsE = 0; dstM = 0; rsD = 0; step("R3 zero");
    clearIn(); dstE = 0; regWrE = 1; memToRegE = 1; step("R3 zero stall");
    // R4
    clearIn(); rsD = 5; rtD = 6; dstM = 6; regWrM = 1; step("R4 cmp");
    // R5
    clearIn(); rtD = 9; dstE = 9; regWrE = 1; memToRegE = 1; step("R5 lduse");
    // R6 and R9
    clearIn(); rsD = 2; dstE = 2; regWrE = 1; branchD = 1; step("R6 brE");
    branchD = 0; step("R9 nobranch E");
    // R7 and R9
    clearIn(); rtD = 8; dstM = 8; regWrM = 1; memToRegM = 1; branchD = 1; step("R7 brM");
    branchD = 0; step("R9 nobranch M");
    memToRegM = 0; branchD = 1; step("R9 nonload M");
    // Random sweep over a small register range
    for (int n = 0; n < 3000; n++) begin
      rsD = REG_W'($urandom_range(0, 3)); rtD = REG_W'($urandom_range(0, 3));
      rsE = REG_W'($urandom_range(0, 3)); rtE = REG_W'($urandom_range(0, 3));
      dstE = REG_W'($urandom_range(0, 3)); dstM = REG_W'($urandom_range(0, 3));
      dstW = REG_W'($urandom_range(0, 3));
      {branchD, regWrE, memToRegE, regWrM, memToRegM, regWrW} = 6'($urandom);
      step("rand");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule